// File: doc/BRIEF.md
# DMA Channel Chaining and Completion Control

This block keeps the control state of every channel in a small multi-channel DMA engine. It does not hold the data path. For each channel it stores a busy flag, an enable bit, a quiet-interrupt bit and a chain target index. Software triggers and chained triggers start idle channels. A done pulse from the data path ends the current block. When a block ends, the channel can start another channel and can raise a sticky interrupt flag. Software clears that flag by writing one to it.

In quiet mode the end of a block raises no interrupt. The interrupt comes instead when software writes a null value to the channel's trigger register, which marks the end of a chain of control blocks. A disabled channel ignores every trigger. If it is busy when disabled, it pauses with its busy flag held and its issue permission withdrawn.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset every busy and interrupt flag is 0, every channel is enabled, quiet mode is off and each chain target equals the channel's own index.
- R2: A software trigger on an idle, enabled channel sets its busy flag at the next clock edge, and `issue_ok[i]` equals `busy[i] AND enable[i]`.
- R3: A trigger on a channel that is already busy has no effect, and a `blk_done[i]` pulse while channel i is busy clears its busy flag at the next edge.
- R4: When channel j completes, the channel named by its chain target becomes busy at the same edge, provided that target is a different channel, is enabled and is idle. A software trigger on the target in the same cycle has the same effect.
- R5: A chain target equal to the channel's own index disables chaining, so completion starts no channel.
- R6: With quiet mode off, completion sets the channel's interrupt flag, and a null write leaves that flag unchanged.
- R7: With quiet mode on, completion leaves the interrupt flag unchanged and a null write to the channel sets it.
- R8: A null write never starts a transfer and leaves busy unchanged. A software trigger on the same channel in the same cycle is suppressed.
- R9: A disabled channel ignores software and chained triggers. A dropped trigger is not queued, so re-enabling the channel does not start it. A busy channel that is disabled keeps busy high with `issue_ok` low, and re-enabling it restores `issue_ok`.
- R10: Writing 1 to `irq_clr[i]` clears interrupt flag i. A set event in the same cycle wins over the clear.
- R11: A configuration write with `cfg_we` high loads `cfg_en`, `cfg_quiet` and `cfg_chain` into channel `cfg_ch` at the next edge. Other channels are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel selected by the configuration write |
| cfg_en | input | 1 | Enable value to write |
| cfg_quiet | input | 1 | Quiet-mode value to write |
| cfg_chain | input | 2 | Chain target index to write |
| sw_trig | input | 4 | Software trigger pulse, one bit per channel |
| null_wr | input | 4 | Null trigger write pulse, one bit per channel |
| blk_done | input | 4 | Block-complete pulse from the data path, one bit per channel |
| irq_clr | input | 4 | Write-one-to-clear strobes for the interrupt flags |
| busy | output | 4 | Busy flags |
| issue_ok | output | 4 | Channel is allowed to issue bus transfers |
| irq | output | 4 | Sticky interrupt flags |

## Verification
The embedded assertions check the per-channel rules on every cycle:
- a channel becomes busy only while it is enabled;
- a paused, disabled channel stays busy;
- completion always drops busy;
- a null write alone never starts a channel;
- quiet mode never raises an interrupt without a null write;
- configuration is stable when no write is made.

Only the bench's scenarios can show the cross-channel effects, because each depends on a particular sequence of stimulus. These are:
- a completion starting the chained channel at the same edge;
- a chain to self doing nothing;
- a dropped chain trigger staying dropped after the target is re-enabled;
- a set event winning over a clear.

// File: rtl/dma_cc_pkg.sv
// Package: shared sizes and the per-channel configuration record.
// Assumes the channel count is a power of two of at least 2.
package dma_cc_pkg;
    localparam int CC_NCH = 4;
    localparam int CC_CW  = $clog2(CC_NCH);

    typedef struct packed {
        logic             en;
        logic             quiet;
        logic [CC_CW-1:0] chain;
    } chan_cfg_t;
endpackage

// File: rtl/dma_cc_cfg.sv
// Module: configuration store for all channels.
// Holds enable, quiet mode and chain target for each channel and loads one
// channel per write. Reset default: enabled, quiet off, chain target equal to
// the channel's own index, which means no chaining.
module dma_cc_cfg
    import dma_cc_pkg::*;
#(
    parameter int NCH = CC_NCH,
    parameter int CW  = CC_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CW-1:0] ch,
    input  chan_cfg_t     wdata,
    output chan_cfg_t     cfg [NCH]
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Load this channel on a matching write; reset to the defaults.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[g].en    <= 1'b1;
                cfg[g].quiet <= 1'b0;
                cfg[g].chain <= CW'(g);
            end else if (we && ch == CW'(g)) begin
                cfg[g] <= wdata;
            end
        end

        // R11: configuration only changes on a write.
        p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !we |=> $stable(cfg[g]));
    end
endmodule

// File: rtl/dma_cc_route.sv
// Module: chain trigger routing.
// Turns completion pulses into trigger pulses for the target channels. A
// channel that names itself produces no trigger. Several sources aimed at the
// same target merge into one trigger. Purely combinational.
module dma_cc_route
    import dma_cc_pkg::*;
#(
    parameter int NCH = CC_NCH,
    parameter int CW  = CC_CW
) (
    input  logic [NCH-1:0] complete,
    input  chan_cfg_t      cfg [NCH],
    output logic [NCH-1:0] chain_trig
);
    // For each target, OR together the completions of every other channel that names it.
    always_comb begin
        chain_trig = '0;
        for (int t = 0; t < NCH; t++) begin
            for (int s = 0; s < NCH; s++) begin
                if (s != t && complete[s] && cfg[s].chain == CW'(t))
                    chain_trig[t] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_cc_chan.sv
// Module: one channel's busy and interrupt state.
// Assumes done_i pulses only mean something while the channel is busy.
// Completion always takes priority over a new start in the same cycle.
module dma_cc_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic quiet_i,
    input  logic sw_trig_i,
    input  logic chain_trig_i,
    input  logic null_i,
    input  logic done_i,
    input  logic clr_i,
    output logic busy_o,
    output logic issue_o,
    output logic irq_o,
    output logic complete_o
);
    logic busy_q, irq_q, start, irq_set;

    // Decode start, completion and interrupt set events.
    always_comb begin
        complete_o = busy_q && done_i;
        start      = en_i && !busy_q && ((sw_trig_i && !null_i) || chain_trig_i);
        irq_set    = (complete_o && !quiet_i) || (null_i && quiet_i);
    end

    // Busy flag: cleared by completion, set by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_q <= 1'b0;
        else if (complete_o) busy_q <= 1'b0;
        else if (start)      busy_q <= 1'b1;
    end

    // Sticky interrupt flag: a set event wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_set || (irq_q && !clr_i);
    end

    assign busy_o  = busy_q;
    assign irq_o   = irq_q;
    assign issue_o = busy_q && en_i;

    // R9: a channel only becomes busy while enabled.
    p_start_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(en_i));
    // R9: a paused channel stays busy.
    p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !en_i && !done_i |=> busy_q);
    // R3: completion drops busy.
    p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && done_i |=> !busy_q);
    // R8: a null write alone never starts the channel.
    p_null_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && null_i && !chain_trig_i |=> !busy_q);
    // R7: in quiet mode only a null write raises the interrupt.
    p_quiet_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_i && !null_i && !irq_q |=> !irq_q);
endmodule

// File: rtl/dma_chain_ctrl.sv
// Module: top of the DMA chaining and completion control.
// Connects the configuration store, the chain router and one channel slice
// per channel. Triggers, null writes and done pulses are one-cycle strobes
// that are synchronous to clk.
module dma_chain_ctrl
    import dma_cc_pkg::*;
#(
    parameter int NCH = CC_NCH,
    parameter int CW  = CC_CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CW-1:0]  cfg_ch,
    input  logic           cfg_en,
    input  logic           cfg_quiet,
    input  logic [CW-1:0]  cfg_chain,
    input  logic [NCH-1:0] sw_trig,
    input  logic [NCH-1:0] null_wr,
    input  logic [NCH-1:0] blk_done,
    input  logic [NCH-1:0] irq_clr,
    output logic [NCH-1:0] busy,
    output logic [NCH-1:0] issue_ok,
    output logic [NCH-1:0] irq
);
    chan_cfg_t      cfg [NCH];
    chan_cfg_t      wdata;
    logic [NCH-1:0] complete;
    logic [NCH-1:0] chain_trig;

    // Pack the configuration write fields into one record.
    always_comb begin
        wdata.en    = cfg_en;
        wdata.quiet = cfg_quiet;
        wdata.chain = cfg_chain;
    end

    dma_cc_cfg #(.NCH(NCH), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .ch(cfg_ch),
        .wdata(wdata), .cfg(cfg)
    );

    dma_cc_route #(.NCH(NCH), .CW(CW)) u_route (
        .complete(complete), .cfg(cfg), .chain_trig(chain_trig)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dma_cc_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .en_i(cfg[g].en), .quiet_i(cfg[g].quiet),
            .sw_trig_i(sw_trig[g]), .chain_trig_i(chain_trig[g]),
            .null_i(null_wr[g]), .done_i(blk_done[g]), .clr_i(irq_clr[g]),
            .busy_o(busy[g]), .issue_o(issue_ok[g]), .irq_o(irq[g]),
            .complete_o(complete[g])
        );
    end
endmodule

// File: tb/test_dma_chain_ctrl.sv
// Bench: a vector table walked by one loop, then directed reset and corner tests.
module test_dma_chain_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_en = 1'b0, cfg_quiet = 1'b0;
    logic [1:0] cfg_ch = '0, cfg_chain = '0;
    logic [3:0] sw_trig = '0, null_wr = '0, blk_done = '0, irq_clr = '0;
    logic [3:0] busy, issue_ok, irq;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    dma_chain_ctrl i_dma_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_en(cfg_en), .cfg_quiet(cfg_quiet), .cfg_chain(cfg_chain),
        .sw_trig(sw_trig), .null_wr(null_wr), .blk_done(blk_done),
        .irq_clr(irq_clr), .busy(busy), .issue_ok(issue_ok), .irq(irq)
    );

    // Vector fields: trig[23:20] null[19:16] done[15:12] clr[11:8] exp_busy[7:4] exp_irq[3:0].
    // Configuration used: ch0 chains to ch1, ch1 chains to itself, ch2 is quiet and
    // chains to ch3, ch3 chains to itself; all channels are enabled (set by R11 writes).
    localparam logic [23:0] VEC [16] = '{
        24'h100010, // R2 start ch0
        24'h100010, // R3 trigger while busy is ignored
        24'h001021, // R4 ch0 completes, chains ch1; R6 irq0
        24'h002003, // R5 ch1 chains to itself; R6 irq1
        24'h000300, // R10 clear both
        24'h400040, // R2 start ch2
        24'h004080, // R7 quiet ch2 completes silently, chains ch3
        24'h040084, // R7 null write raises irq2
        24'h00800C, // R6 ch3 completes
        24'h08000C, // R6 null write with quiet off: no change
        24'h11000C, // R8 trigger together with null is suppressed
        24'h04040C, // R10 set wins over clear
        24'h000C00, // R10 clear
        24'h100010, // R2 start ch0
        24'h201021, // R4 chain and software trigger on the same target
        24'h002102  // R10 clear ch0 while ch1 sets
    };

    task automatic chk(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Apply one cycle of strobes, let the edge register them, sample at the negedge.
    task automatic step(input logic [3:0] t, input logic [3:0] n,
                        input logic [3:0] d, input logic [3:0] c);
        sw_trig = t; null_wr = n; blk_done = d; irq_clr = c;
        @(posedge clk); #1;
        sw_trig = '0; null_wr = '0; blk_done = '0; irq_clr = '0;
        @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [1:0] ch, input logic en,
                          input logic q, input logic [1:0] chn);
        cfg_we = 1'b1; cfg_ch = ch; cfg_en = en; cfg_quiet = q; cfg_chain = chn;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        chk("R1", "busy after reset", busy, 4'h0);
        chk("R1", "irq after reset", irq, 4'h0);
        chk("R1", "issue after reset", issue_ok, 4'h0);
        // R1 defaults: ch2 enabled, quiet off, chains to itself.
        step(4'h4, 4'h0, 4'h0, 4'h0);
        chk("R1", "default enabled start", busy, 4'h4);
        step(4'h0, 4'h0, 4'h4, 4'h0);
        chk("R1", "default self chain busy", busy, 4'h0);
        chk("R1", "default quiet off irq", irq, 4'h4);
        step(4'h0, 4'h0, 4'h0, 4'h4);
        chk("R10", "clear", irq, 4'h0);

        // R11 configuration writes.
        cfg_wr(2'd0, 1'b1, 1'b0, 2'd1);
        cfg_wr(2'd2, 1'b1, 1'b1, 2'd3);
        for (int k = 0; k < 16; k++) begin
            step(VEC[k][23:20], VEC[k][19:16], VEC[k][15:12], VEC[k][11:8]);
            chk("R2-table", "busy", busy, VEC[k][7:4]);
            chk("R6-table", "irq", irq, VEC[k][3:0]);
            chk("R2", "issue_ok", issue_ok, VEC[k][7:4]);
        end
        step(4'h0, 4'h0, 4'h0, 4'hF);

        // R9 disabled channel ignores triggers, chained triggers are dropped.
        cfg_wr(2'd1, 1'b0, 1'b0, 2'd1);
        step(4'h2, 4'h0, 4'h0, 4'h0);
        chk("R9", "sw trigger on disabled", busy, 4'h0);
        step(4'h1, 4'h0, 4'h0, 4'h0);
        chk("R9", "ch0 start", busy, 4'h1);
        step(4'h0, 4'h0, 4'h1, 4'h0);
        chk("R9", "chain to disabled dropped", busy, 4'h0);
        cfg_wr(2'd1, 1'b1, 1'b0, 2'd1);
        chk("R9", "no queued start on re-enable", busy, 4'h0);

        // R9 pause: disable a busy channel.
        step(4'h8, 4'h0, 4'h0, 4'h0);
        chk("R9", "ch3 busy", busy, 4'h8);
        cfg_wr(2'd3, 1'b0, 1'b0, 2'd3);
        chk("R9", "paused busy held", busy, 4'h8);
        chk("R9", "paused issue withdrawn", issue_ok, 4'h0);
        step(4'h8, 4'h0, 4'h0, 4'h0);
        chk("R9", "paused trigger ignored", busy, 4'h8);
        cfg_wr(2'd3, 1'b1, 1'b0, 2'd3);
        chk("R9", "resumed issue", issue_ok, 4'h8);
        step(4'h0, 4'h0, 4'h8, 4'h0);
        chk("R3", "completion clears busy", busy, 4'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule